// File: doc/BRIEF.md
# SD Host Register Front-End

This block is the 32-bit register front-end placed ahead of a standard SD host slot controller. It answers a 4 KB window on a simple register bus. The lower 512 bytes are a bank of 128 host registers, and three of them have special write behaviour. Every word address from 0x200 up to the top of the window is passed to a downstream slot register port, with the address rebased so that 0x200 becomes offset 0.

A write that sets the soft-reset bit of the information register returns the whole host bank to its power-on contents. It also sends a one-cycle reset pulse to the slot controller. In the PHY access register, the acknowledge bit is derived from the read and write request bits of each write. In the eMMC control register, the tuning bit never keeps a 1. The slot controller's interrupt line passes straight through to the block's interrupt output. Host register accesses finish in the cycle they are presented. Forwarded accesses take their completion and read data from the slot port.

Top module: `sdhost_regfront`

## Requirements
- R1: After hardware reset, the word at byte offset 0x000 reads 0x00010000 and every other host word (0x004 to 0x1FC) reads 0.
- R2: A write to offset 0x000 with data bit 0 set returns every host word to its R1 value from the next cycle on. Bit 0 of offset 0x000 never reads as 1.
- R3: `slot_rst_pulse` is high in the single cycle that follows the clock edge accepting a soft-reset write, and is low again in the cycle after that. It is also high while `rst_n` is low.
- R4: On a write to offset 0x010, stored bit 26 equals (written bit 24 OR written bit 25), whatever value bit 26 carried. All other bits are stored as written.
- R5: On a write to offset 0x018, stored bit 15 is 0. All other bits are stored as written.
- R6: A write to any other aligned host offset below 0x200 stores all 32 bits. A write to offset 0x000 without bit 0 leaves the word at 0x00010000.
- R7: A host access (aligned, address below 0x200) has `bus_ready` high in the same cycle. A read returns the stored word combinationally.
- R8: An aligned access at 0x200 or above drives `slot_we`/`slot_re` with the bus strobes, `slot_addr` = address − 0x200, and `slot_wdata` = `bus_wdata`. It modifies no host word.
- R9: For a forwarded access, `bus_rdata` equals `slot_rdata` and `bus_ready` equals `slot_ready`.
- R10: An access whose address bits [1:0] are not 00 does not forward (`slot_we` and `slot_re` stay 0) and changes no host word. A read returns 0, and `bus_ready` is 1.
- R11: `irq_out` follows `slot_irq` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | 12 | Byte address inside the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes this cycle |
| slot_addr | output | 12 | Rebased byte offset to the slot port |
| slot_we | output | 1 | Forwarded write strobe |
| slot_re | output | 1 | Forwarded read strobe |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Read data from the slot port |
| slot_ready | input | 1 | Completion from the slot port |
| slot_rst_pulse | output | 1 | Reset pulse to the slot controller |
| slot_irq | input | 1 | Interrupt from the slot controller |
| irq_out | output | 1 | Interrupt output |

## Verification
The assertions assume that the bus never raises the write and read strobes together. They also assume that a write is held for exactly one clock edge, so every accepted write produces exactly one register update or one soft reset. The stimulus follows these rules. Every access is presented on a falling edge with only one strobe set, and it is withdrawn on the next falling edge. Forwarded accesses in the stimulus are answered by a stateless slot model whose read data depends only on the rebased offset, so that offset is visible in `bus_rdata`.

// File: rtl/sdhost_regfront_pkg.sv
package sdhost_regfront_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IDX_INFO  = 0;   // byte offset 0x000
  localparam int unsigned IDX_PHY   = 4;   // byte offset 0x010
  localparam int unsigned IDX_EMMC  = 6;   // byte offset 0x018
  localparam int unsigned BIT_SWR   = 0;
  localparam int unsigned BIT_PWR   = 24;
  localparam int unsigned BIT_PRD   = 25;
  localparam int unsigned BIT_PACK  = 26;
  localparam int unsigned BIT_TUNE  = 15;
  localparam logic [WORD_W-1:0] INFO_POR = 32'h0001_0000;

  // power-on value of a host word
  function automatic logic [WORD_W-1:0] por_value(input int unsigned idx);
    return (idx == IDX_INFO) ? INFO_POR : '0;
  endfunction

  // value kept when a host word is written
  function automatic logic [WORD_W-1:0] shape_write(input int unsigned idx,
                                                    input logic [WORD_W-1:0] wd,
                                                    input logic [WORD_W-1:0] old);
    logic [WORD_W-1:0] v;
    v = wd;
    case (idx)
      IDX_INFO: v = old;
      IDX_PHY:  v[BIT_PACK] = wd[BIT_PWR] | wd[BIT_PRD];
      IDX_EMMC: v[BIT_TUNE] = 1'b0;
      default:  v = wd;
    endcase
    return v;
  endfunction

  // true when a write carries the soft-reset request
  function automatic logic is_soft_reset(input int unsigned idx,
                                         input logic [WORD_W-1:0] wd);
    return (idx == IDX_INFO) && wd[BIT_SWR];
  endfunction

endpackage

// File: rtl/sdhost_regfront_decode.sv
module sdhost_regfront_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_BASE = 'h200,
  localparam int unsigned IDX_W    = $clog2(SLOT_BASE / 4)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_host,
  output logic              acc_slot,
  output logic              acc_misaligned,
  output logic [IDX_W-1:0]  host_idx,
  output logic [ADDR_W-1:0] slot_off
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(SLOT_BASE);

  logic aligned;
  logic upper;

  always_comb begin
    aligned        = (addr[1:0] == 2'b00);
    upper          = (addr >= BASE_V);
    acc_misaligned = !aligned;
    acc_host       = aligned && !upper;
    acc_slot       = aligned && upper;
    host_idx       = addr[IDX_W+1:2];
    slot_off       = upper ? (addr - BASE_V) : '0;
  end

endmodule

// File: rtl/sdhost_regfront_bank.sv
module sdhost_regfront_bank
  import sdhost_regfront_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              soft_evt
);
  logic [WORD_W-1:0] regs_q [WORDS];

  assign soft_evt = wr_en && is_soft_reset(int'(idx), wdata);
  assign rd_data  = regs_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) regs_q[i] <= por_value(i);
    end else if (soft_evt) begin
      for (int i = 0; i < WORDS; i++) regs_q[i] <= por_value(i);
    end else if (wr_en) begin
      for (int i = 0; i < WORDS; i++)
        if (int'(idx) == i) regs_q[i] <= shape_write(i, wdata, regs_q[i]);
    end
  end

  // R4
  phy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(idx) == IDX_PHY) |=>
      (regs_q[IDX_PHY][BIT_PACK] == ($past(wdata[BIT_PWR]) || $past(wdata[BIT_PRD]))));

  // R5
  tune_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(idx) == IDX_EMMC) |=> !regs_q[IDX_EMMC][BIT_TUNE]);

  // R2
  soft_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_evt |=> (regs_q[IDX_INFO] == INFO_POR && regs_q[IDX_PHY] == '0));

endmodule

// File: rtl/sdhost_regfront_pulse.sv
module sdhost_regfront_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b1;
    else        pulse_q <= trig;
  end

  assign pulse = pulse_q;

  // R3
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> !pulse);

endmodule

// File: rtl/sdhost_regfront.sv
module sdhost_regfront
  import sdhost_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_BASE = 'h200,
  localparam int unsigned WORDS    = SLOT_BASE / 4,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_we,
  output logic              slot_re,
  output logic [WORD_W-1:0] slot_wdata,
  input  logic [WORD_W-1:0] slot_rdata,
  input  logic              slot_ready,
  output logic              slot_rst_pulse,
  input  logic              slot_irq,
  output logic              irq_out
);
  logic              acc_host;
  logic              acc_slot;
  logic              acc_misaligned;
  logic [IDX_W-1:0]  host_idx;
  logic [WORD_W-1:0] host_rd;
  logic              host_wr;
  logic              soft_evt;

  sdhost_regfront_decode #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)) dec_i (
    .addr           (bus_addr),
    .acc_host       (acc_host),
    .acc_slot       (acc_slot),
    .acc_misaligned (acc_misaligned),
    .host_idx       (host_idx),
    .slot_off       (slot_addr)
  );

  assign host_wr = bus_we && acc_host;

  sdhost_regfront_bank #(.WORDS(WORDS)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr),
    .idx      (host_idx),
    .wdata    (bus_wdata),
    .rd_data  (host_rd),
    .soft_evt (soft_evt)
  );

  sdhost_regfront_pulse pulse_i (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (soft_evt),
    .pulse (slot_rst_pulse)
  );

  assign slot_we    = bus_we && acc_slot;
  assign slot_re    = bus_re && acc_slot;
  assign slot_wdata = bus_wdata;
  assign irq_out    = slot_irq;

  always_comb begin
    if (acc_slot) begin
      bus_rdata = slot_rdata;
      bus_ready = slot_ready;
    end else begin
      bus_rdata = acc_host ? host_rd : '0;
      bus_ready = 1'b1;
    end
  end

  // R10
  misalign_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_misaligned |-> (!slot_we && !slot_re && !soft_evt));

  // R7
  host_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_host |-> bus_ready);

  // R8
  fwd_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we || slot_re) |-> (bus_addr >= ADDR_W'(SLOT_BASE) && bus_addr[1:0] == 2'b00));

endmodule

// File: tb/sdhost_regfront_tb_top.sv
module sdhost_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [11:0] slot_addr;
  logic        slot_we;
  logic        slot_re;
  logic [31:0] slot_wdata;
  logic [31:0] slot_rdata;
  logic        slot_ready = 1'b1;
  logic        slot_rst_pulse;
  logic        slot_irq = 1'b0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // stateless slot model: read data encodes the rebased offset
  assign slot_rdata = 32'h5A00_0000 | {20'h0, slot_addr};

  sdhost_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .slot_addr(slot_addr), .slot_we(slot_we),
    .slot_re(slot_re), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
    .slot_ready(slot_ready), .slot_rst_pulse(slot_rst_pulse),
    .slot_irq(slot_irq), .irq_out(irq_out)
  );

  // {addr, req, write data, expected read-back}
  localparam int NV = 9;
  localparam logic [11:0] V_ADDR [NV] = '{12'h004, 12'h1FC, 12'h010, 12'h010,
                                          12'h010, 12'h010, 12'h018, 12'h018, 12'h000};
  localparam int V_REQ [NV] = '{6, 6, 4, 4, 4, 4, 5, 5, 6};
  localparam logic [31:0] V_WD [NV] = '{
    32'hDEAD_BEEF,   // R6 plain word
    32'h1234_5678,   // R6 last host word
    32'h0100_0000,   // R4 write request sets ack
    32'h0200_0055,   // R4 read request sets ack
    32'h0400_0000,   // R4 ack alone is dropped
    32'h07FF_FFFF,   // R4 all three set
    32'hFFFF_FFFF,   // R5 tune bit cleared
    32'h0000_8001,   // R5 only tune and bit 0
    32'hFFFF_FFFE    // R6 info word ignores data without soft reset
  };
  localparam logic [31:0] V_EXP [NV] = '{32'hDEAD_BEEF, 32'h1234_5678, 32'h0500_0000,
                                         32'h0600_0055, 32'h0000_0000, 32'h07FF_FFFF,
                                         32'hFFFF_7FFF, 32'h0000_0001, 32'h0001_0000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    #1;
    d = bus_rdata; rdy = bus_ready;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic rdy;
    // R3 pulse while hardware reset held
    #7;
    check("R3 pulse in reset", {31'h0, slot_rst_pulse}, 32'h1);
    #10 rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 pulse drops after reset", {31'h0, slot_rst_pulse}, 32'h0);

    // R1 reset values
    do_read(12'h000, rd, rdy); check("R1 info word", rd, 32'h0001_0000);
    do_read(12'h010, rd, rdy); check("R1 phy word", rd, 32'h0);
    do_read(12'h1FC, rd, rdy); check("R1 last word", rd, 32'h0);
    // R7 ready on host access
    check("R7 host ready", {31'h0, rdy}, 32'h1);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      do_write(V_ADDR[i], V_WD[i]);
      do_read(V_ADDR[i], rd, rdy);
      check($sformatf("R%0d vector %0d", V_REQ[i], i), rd, V_EXP[i]);
    end

    // R2 / R3 soft reset
    do_write(12'h020, 32'hCAFE_F00D);
    @(negedge clk);
    bus_addr = 12'h000; bus_wdata = 32'h0000_0001; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R3 pulse after soft reset", {31'h0, slot_rst_pulse}, 32'h1);
    @(negedge clk);
    check("R3 pulse single cycle", {31'h0, slot_rst_pulse}, 32'h0);
    do_read(12'h020, rd, rdy); check("R2 word cleared", rd, 32'h0);
    do_read(12'h018, rd, rdy); check("R2 emmc cleared", rd, 32'h0);
    do_read(12'h000, rd, rdy); check("R2 info restored", rd, 32'h0001_0000);

    // R8 forwarded write
    @(negedge clk);
    bus_addr = 12'h20C; bus_wdata = 32'hA1B2_C3D4; bus_we = 1'b1;
    #1;
    check("R8 slot_we", {31'h0, slot_we}, 32'h1);
    check("R8 slot_addr", {20'h0, slot_addr}, 32'h00C);
    check("R8 slot_wdata", slot_wdata, 32'hA1B2_C3D4);
    @(negedge clk);
    bus_we = 1'b0;
    do_read(12'h00C, rd, rdy); check("R8 host word untouched", rd, 32'h0);

    // R9 forwarded read data and ready
    do_read(12'hFFC, rd, rdy);
    check("R9 slot rdata", rd, 32'h5A00_0DFC);
    check("R9 slot ready", {31'h0, rdy}, 32'h1);
    slot_ready = 1'b0;
    do_read(12'h240, rd, rdy);
    check("R9 slot stall", {31'h0, rdy}, 32'h0);
    check("R9 slot rdata 0x40", rd, 32'h5A00_0040);
    slot_ready = 1'b1;

    // R10 misaligned accesses
    @(negedge clk);
    bus_addr = 12'h006; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
    #1;
    check("R10 no forward", {30'h0, slot_we, slot_re}, 32'h0);
    check("R10 ready", {31'h0, bus_ready}, 32'h1);
    @(negedge clk);
    bus_we = 1'b0;
    do_read(12'h004, rd, rdy); check("R10 word 1 untouched", rd, 32'h0);
    do_read(12'h006, rd, rdy); check("R10 read zero", rd, 32'h0);
    @(negedge clk);
    bus_addr = 12'h202; bus_re = 1'b1;
    #1;
    check("R10 upper no forward", {31'h0, slot_re}, 32'h0);
    check("R10 upper read zero", bus_rdata, 32'h0);
    @(negedge clk);
    bus_re = 1'b0;
    do_write(12'h001, 32'h0000_0001);
    check("R10 misaligned soft reset ignored", {31'h0, slot_rst_pulse}, 32'h0);

    // R11 interrupt pass-through
    slot_irq = 1'b1; #1;
    check("R11 irq high", {31'h0, irq_out}, 32'h1);
    slot_irq = 1'b0; #1;
    check("R11 irq low", {31'h0, irq_out}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule